// File: doc/BRIEF.md
# Variable-Page TLB Translation Unit

This block is a fully associative translation lookaside buffer. It turns a virtual address into a physical address for a read, a write or an instruction fetch. Each entry covers one page, and the page can be any power-of-four size from 1 KB to 16 MB. Every entry is compared against the request in the same cycle. The lowest-indexed qualifying entry decides the outcome, which is one of miss, protection fault or hit. A hit also returns the physical address, the page-size code and the entry index.

Each entry holds three things: a tag word, a data word and an owner process ID. The tag word carries the page number, a size code and a valid bit. The data word carries the frame number, the execute and write rights, and a zone number. The zone number selects a 2-bit field of a zone protection word. That field can hide the entry from user code, keep the entry's own rights, or grant execute and write to supervisor code or to everyone.

Entries are loaded through a simple indexed write port. The current process ID and the zone protection word come in as inputs. The result is registered, so it appears one clock after the request.

Top module: `tlb_xlate`

## Requirements
- R1: The page-size code is tag bits [9:7]. Code c selects a page of 1 KB times 4 to the power c, so codes 0 to 7 give 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB.
- R2: An entry can match only if tag bit 6 (valid) is 1. It matches only if the virtual address and the tag word agree on every bit at or above the page size.
- R3: An entry whose stored process ID is zero matches any `pid_i`. Any other stored ID must equal `pid_i` for the entry to match.
- R4: When several entries qualify, the one with the lowest index decides the result.
- R5: The zone number is data bits [7:4]. Zone z reads bits [31-2z:30-2z] of `zpr_i`, so zone 0 sits in the two top bits. With field value 0, a user access (`req_user_i`=1) skips the entry and the search goes on to the next entry. With field value 0, a supervisor access uses the entry's own rights.
- R6: The entry's write right is data bit 8 and its execute right is data bit 9. Field value 1 keeps these rights. Field value 2 grants both rights to supervisor accesses only. Field value 3 grants both rights to all accesses.
- R7: `req_kind_i` is 0 for read, 1 for write and 2 for fetch. `rsp_status_o` is 0 for miss, 1 for protection fault and 2 for hit. A read of a matched entry always hits. A write without the write right is a fault, and so is a fetch without the execute right. A fault returns the entry index.
- R8: On a hit, `rsp_paddr_o` is built from the data word's bits above the page size and the virtual address's bits below it, and the result is ANDed with ADDR_MASK. On a hit, `rsp_size_o` is the size code and `rsp_idx_o` is the entry index.
- R9: With ZONES_EN=0, or with a zone number greater than NUM_ZONES, the entry's own rights apply and `zpr_i` is ignored.
- R10: A request sampled on one rising edge gives its result on the next edge. `rsp_valid_o` copies `req_valid_i`. On a miss, and on a fault, `rsp_paddr_o` and `rsp_size_o` are zero. On a miss, `rsp_idx_o` is also zero.
- R11: Reset clears `rsp_valid_o` and invalidates every entry, so a lookup right after reset misses.
- R12: When `wr_en_i` is high at a rising edge, entry `wr_idx_i` takes `wr_tag_i`, `wr_data_i` and `wr_pid_i`. A lookup in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_tag_i | input | 32 | Tag word to store |
| wr_data_i | input | 32 | Data word to store |
| wr_pid_i | input | PID_W | Owner process ID to store |
| req_valid_i | input | 1 | Lookup request valid |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | 1 for user mode, 0 for supervisor mode |
| pid_i | input | PID_W | Current process ID |
| zpr_i | input | 32 | Zone protection word |
| rsp_valid_o | output | 1 | Result valid |
| rsp_status_o | output | 2 | 0 miss, 1 protection fault, 2 hit |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_size_o | output | 3 | Page-size code of the hit entry |
| rsp_idx_o | output | IDX_W | Index of the deciding entry |

## Verification
The bench builds the block with 8 entries and NUM_ZONES=4. At that setting, zone 4 still reads the protection word and zone 7 lies past the limit, so both sides of the out-of-range rule can be checked. ADDR_MASK is set to 0x3FFFFFFF, which clears the top frame bits and makes the address mask visible in the results. A second copy built with ZONES_EN=0 gets the same stimulus and shows the protection word being ignored. Overlapping entries that differ only in process ID or zone cover the lowest-index priority and the rule that lets the search continue past an entry hidden from user code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W        = 32;
  localparam int MIN_PAGE_BITS = 10;
  localparam int TAG_VALID_BIT = 6;
  localparam int SIZE_LSB      = 7;
  localparam int SIZE_W        = 3;
  localparam int DATA_WR_BIT   = 8;
  localparam int DATA_EX_BIT   = 9;
  localparam int ZONE_LSB      = 4;
  localparam int ZONE_W        = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RSP_MISS  = 2'd0,
    RSP_FAULT = 2'd1,
    RSP_HIT   = 2'd2
  } rsp_e;

  // ones above the page offset for a given size code
  function automatic logic [WORD_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
    logic [4:0] sh;
    sh = 5'(MIN_PAGE_BITS) + {1'b0, code, 1'b0};
    return ~((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int PID_W       = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [IDX_W-1:0]                    wr_idx_i,
  input  logic [WORD_W-1:0]                   wr_tag_i,
  input  logic [WORD_W-1:0]                   wr_data_i,
  input  logic [PID_W-1:0]                    wr_pid_i,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0]  tag_o,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0]  data_o,
  output logic [NUM_ENTRIES-1:0][PID_W-1:0]   pid_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[g]  <= '0;
        data_o[g] <= '0;
        pid_o[g]  <= '0;
      end else if (sel) begin
        tag_o[g]  <= wr_tag_i;
        data_o[g] <= wr_data_i;
        pid_o[g]  <= wr_pid_i;
      end
    end
  end
endmodule

// File: rtl/tlb_zone_perm.sv
module tlb_zone_perm
  import tlb_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  parameter bit ZONES_EN  = 1'b1
) (
  input  logic [WORD_W-1:0] zpr_i,
  input  logic [ZONE_W-1:0] zone_i,
  input  logic              user_i,
  input  logic              wr_bit_i,
  input  logic              ex_bit_i,
  output logic              skip_o,
  output logic              wr_o,
  output logic              ex_o
);
  logic [1:0] zcode;

  if (ZONES_EN) begin : g_zones
    logic [WORD_W-1:0] zsh;
    logic              out_of_range;
    assign zsh          = zpr_i >> (5'd30 - {zone_i, 1'b0});
    assign out_of_range = ({28'd0, zone_i} > 32'(NUM_ZONES));
    assign zcode        = out_of_range ? 2'd1 : zsh[1:0];
  end else begin : g_no_zones
    logic unused_zone;
    assign unused_zone = ^{zpr_i, zone_i};
    assign zcode       = 2'd1;
  end

  always_comb begin
    skip_o = (zcode == 2'd0) && user_i;
    wr_o   = wr_bit_i;
    ex_o   = ex_bit_i;
    if (zcode == 2'd3 || (zcode == 2'd2 && !user_i)) begin
      wr_o = 1'b1;
      ex_o = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N      = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest set index is written last
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int          NUM_ENTRIES = 64,
  parameter int          PID_W       = 8,
  parameter int          NUM_ZONES   = 16,
  parameter bit          ZONES_EN    = 1'b1,
  parameter logic [31:0] ADDR_MASK   = 32'hFFFF_FFFF,
  localparam int         IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_tag_i,
  input  logic [31:0]       wr_data_i,
  input  logic [PID_W-1:0]  wr_pid_i,
  input  logic              req_valid_i,
  input  logic [31:0]       req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_user_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [31:0]       zpr_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [31:0]       rsp_paddr_o,
  output logic [2:0]        rsp_size_o,
  output logic [IDX_W-1:0]  rsp_idx_o
);
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] tag_q, data_q, pmask;
  logic [NUM_ENTRIES-1:0][PID_W-1:0]  pid_q;
  logic [NUM_ENTRIES-1:0]             qual, eff_wr, eff_ex;

  tlb_entry_store #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .PID_W      (PID_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_tag_i (wr_tag_i),
    .wr_data_i(wr_data_i),
    .wr_pid_i (wr_pid_i),
    .tag_o    (tag_q),
    .data_o   (data_q),
    .pid_o    (pid_q)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic addr_hit, pid_hit, skip;

    assign pmask[g] = page_mask(tag_q[g][SIZE_LSB +: SIZE_W]);
    assign addr_hit = (((req_vaddr_i ^ tag_q[g]) & pmask[g]) == '0);
    assign pid_hit  = (pid_q[g] == '0) || (pid_q[g] == pid_i);

    tlb_zone_perm #(
      .NUM_ZONES(NUM_ZONES),
      .ZONES_EN (ZONES_EN)
    ) u_zone (
      .zpr_i   (zpr_i),
      .zone_i  (data_q[g][ZONE_LSB +: ZONE_W]),
      .user_i  (req_user_i),
      .wr_bit_i(data_q[g][DATA_WR_BIT]),
      .ex_bit_i(data_q[g][DATA_EX_BIT]),
      .skip_o  (skip),
      .wr_o    (eff_wr[g]),
      .ex_o    (eff_ex[g])
    );

    assign qual[g] = tag_q[g][TAG_VALID_BIT] & addr_hit & pid_hit & ~skip;
  end

  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;

  tlb_prio_enc #(.N(NUM_ENTRIES)) u_prio (
    .req_i  (qual),
    .found_o(sel_found),
    .idx_o  (sel_idx)
  );

  rsp_e              status_c;
  logic [WORD_W-1:0] paddr_c, sel_mask;
  logic [2:0]        size_c;
  logic [IDX_W-1:0]  idx_c;

  always_comb begin
    sel_mask = pmask[sel_idx];
    status_c = RSP_MISS;
    paddr_c  = '0;
    size_c   = '0;
    idx_c    = '0;
    if (sel_found) begin
      idx_c = sel_idx;
      if ((req_kind_i == ACC_WRITE && !eff_wr[sel_idx]) ||
          (req_kind_i == ACC_FETCH && !eff_ex[sel_idx])) begin
        status_c = RSP_FAULT;
      end else begin
        status_c = RSP_HIT;
        paddr_c  = ((data_q[sel_idx] & sel_mask) | (req_vaddr_i & ~sel_mask)) & ADDR_MASK;
        size_c   = tag_q[sel_idx][SIZE_LSB +: SIZE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= RSP_MISS;
      rsp_paddr_o  <= '0;
      rsp_size_o   <= '0;
      rsp_idx_o    <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_status_o <= status_c;
      rsp_paddr_o  <= paddr_c;
      rsp_size_o   <= size_c;
      rsp_idx_o    <= idx_c;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
#(
  parameter logic [31:0] ADDR_MASK = 32'hFFFF_FFFF,
  parameter int          IDX_W     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [31:0]      req_vaddr_i,
  input logic [1:0]       req_kind_i,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_status_o,
  input logic [31:0]      rsp_paddr_o,
  input logic [2:0]       rsp_size_o,
  input logic [IDX_W-1:0] rsp_idx_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R10

  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R10

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_MISS) |->
      (rsp_paddr_o == '0 && rsp_size_o == '0 && rsp_idx_o == '0)); // R10

  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_status_o != 2'd3)); // R7

  AST_READ_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_FAULT) |->
      ($past(req_kind_i) == ACC_WRITE || $past(req_kind_i) == ACC_FETCH)); // R7

  AST_HIT_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_HIT) |->
      (rsp_paddr_o[9:0] == ($past(req_vaddr_i[9:0]) & ADDR_MASK[9:0]))); // R8
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .ADDR_MASK(ADDR_MASK),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .req_kind_i  (req_kind_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_size_o  (rsp_size_o),
  .rsp_idx_o   (rsp_idx_o)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int          NE    = 8;
  localparam int          IW    = 3;
  localparam logic [31:0] AMASK = 32'h3FFF_FFFF;
  localparam logic [31:0] ZPR   = 32'h5B3F_FFFF; // z0=1 z1=1 z2=2 z3=3 z4=0 rest=3

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_tag = '0, wr_data = '0;
  logic [7:0]    wr_pid = '0;
  logic          rq_v = 1'b0, rq_user = 1'b0;
  logic [31:0]   rq_va = '0;
  logic [1:0]    rq_kind = '0;
  logic [7:0]    cur_pid = '0;
  logic [31:0]   zpr = ZPR;

  logic          v_a, v_b;
  logic [1:0]    st_a, st_b;
  logic [31:0]   pa_a, pa_b;
  logic [2:0]    sz_a, sz_b;
  logic [IW-1:0] ix_a, ix_b;

  tlb_xlate #(.NUM_ENTRIES(NE), .NUM_ZONES(4), .ZONES_EN(1'b1), .ADDR_MASK(AMASK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
    .wr_data_i(wr_data), .wr_pid_i(wr_pid), .req_valid_i(rq_v), .req_vaddr_i(rq_va),
    .req_kind_i(rq_kind), .req_user_i(rq_user), .pid_i(cur_pid), .zpr_i(zpr),
    .rsp_valid_o(v_a), .rsp_status_o(st_a), .rsp_paddr_o(pa_a), .rsp_size_o(sz_a), .rsp_idx_o(ix_a));

  tlb_xlate #(.NUM_ENTRIES(NE), .NUM_ZONES(4), .ZONES_EN(1'b0), .ADDR_MASK(AMASK)) dut_nz (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
    .wr_data_i(wr_data), .wr_pid_i(wr_pid), .req_valid_i(rq_v), .req_vaddr_i(rq_va),
    .req_kind_i(rq_kind), .req_user_i(rq_user), .pid_i(cur_pid), .zpr_i(zpr),
    .rsp_valid_o(v_b), .rsp_status_o(st_b), .rsp_paddr_o(pa_b), .rsp_size_o(sz_b), .rsp_idx_o(ix_b));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0]   va;
    logic [1:0]    kind;
    logic          user;
    logic [7:0]    pid;
    logic [1:0]    st;
    logic [31:0]   pa;
    logic [2:0]    sz;
    logic [IW-1:0] ix;
  } vec_t;

  // kind 0 rd 1 wr 2 fetch; st 0 miss 1 fault 2 hit
  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0000_1234, 2'd0, 1'b0, 8'h05, 2'd2, 32'h0000_3234, 3'd1, 3'd0}, // R4 R8 R1
    '{32'h0000_1234, 2'd1, 1'b0, 8'h05, 2'd1, 32'h0,         3'd0, 3'd0}, // R7 write fault
    '{32'h0000_1234, 2'd1, 1'b0, 8'h06, 2'd2, 32'h0004_0234, 3'd1, 3'd1}, // R3 pid mismatch
    '{32'h0000_1FFC, 2'd2, 1'b1, 8'h00, 2'd2, 32'h0004_0FFC, 3'd1, 3'd1}, // R3 R6
    '{32'h01AB_CDEF, 2'd0, 1'b0, 8'h05, 2'd2, 32'h02AB_CDEF, 3'd7, 3'd2}, // R1 R8 16MB
    '{32'h01AB_CDEF, 2'd1, 1'b0, 8'h05, 2'd2, 32'h02AB_CDEF, 3'd7, 3'd2}, // R6 zone2 sup
    '{32'h01AB_CDEF, 2'd1, 1'b1, 8'h05, 2'd1, 32'h0,         3'd0, 3'd2}, // R6 zone2 user
    '{32'h01AB_CDEF, 2'd2, 1'b1, 8'h05, 2'd2, 32'h02AB_CDEF, 3'd7, 3'd2}, // R7 fetch ok
    '{32'h2000_07FF, 2'd2, 1'b1, 8'h05, 2'd2, 32'h0000_8BFF, 3'd0, 3'd3}, // R6 zone3 R1 1KB
    '{32'h2000_0BFF, 2'd0, 1'b0, 8'h05, 2'd0, 32'h0,         3'd0, 3'd0}, // R2 past 1KB
    '{32'h3000_FFFF, 2'd1, 1'b0, 8'h05, 2'd1, 32'h0,         3'd0, 3'd4}, // R9 zone 7
    '{32'h3001_0000, 2'd0, 1'b0, 8'h05, 2'd0, 32'h0,         3'd0, 3'd0}, // R2 past 64KB
    '{32'h4000_0010, 2'd0, 1'b0, 8'h05, 2'd0, 32'h0,         3'd0, 3'd0}, // R2 invalid
    '{32'h500F_0000, 2'd0, 1'b1, 8'h05, 2'd0, 32'h0,         3'd0, 3'd0}, // R5 user skip
    '{32'h500F_0000, 2'd1, 1'b0, 8'h05, 2'd1, 32'h0,         3'd0, 3'd6}, // R5 sup own bits
    '{32'h500F_0000, 2'd0, 1'b0, 8'h05, 2'd2, 32'h007F_0000, 3'd5, 3'd6}, // R5 R8 1MB
    '{32'h6000_0ABC, 2'd1, 1'b1, 8'h09, 2'd2, 32'h0000_2ABC, 3'd1, 3'd7}, // R3
    '{32'h6000_0ABC, 2'd0, 1'b0, 8'h05, 2'd0, 32'h0,         3'd0, 3'd0}  // R3 owner differs
  };

  function automatic logic [31:0] mk_tag(logic [31:0] base, logic [2:0] code, logic v);
    return base | (32'(code) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mk_data(logic [31:0] rpn, logic ex, logic wr, logic [3:0] z);
    return rpn | (32'(ex) << 9) | (32'(wr) << 8) | (32'(z) << 4);
  endfunction

  task automatic put(int idx, logic [31:0] t, logic [31:0] d, logic [7:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_tag = t; wr_data = d; wr_pid = p;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] k, logic u, logic [7:0] p);
    @(negedge clk);
    rq_v = 1'b1; rq_va = va; rq_kind = k; rq_user = u; cur_pid = p;
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] pk(logic v, logic [1:0] s, logic [31:0] a, logic [2:0] z, logic [IW-1:0] i);
    return 64'({v, s, a, z, i});
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset valid", 64'(v_a), 64'd0);
    rst_n = 1'b1;
    look(32'h0000_1234, 2'd0, 1'b0, 8'h05);
    chk("R11", "lookup after reset", pk(v_a, st_a, pa_a, sz_a, ix_a), pk(1'b1, 2'd0, 32'h0, 3'd0, '0));

    // R12 load entries
    put(0, mk_tag(32'h0000_1000, 3'd1, 1'b1), mk_data(32'h8000_3000, 1'b0, 1'b0, 4'd0), 8'h05);
    put(1, mk_tag(32'h0000_1000, 3'd1, 1'b1), mk_data(32'h0004_0000, 1'b1, 1'b1, 4'd1), 8'h00);
    put(2, mk_tag(32'h0100_0000, 3'd7, 1'b1), mk_data(32'hC200_0000, 1'b1, 1'b0, 4'd2), 8'h00);
    put(3, mk_tag(32'h2000_0400, 3'd0, 1'b1), mk_data(32'h0000_8800, 1'b0, 1'b0, 4'd3), 8'h00);
    put(4, mk_tag(32'h3000_0000, 3'd3, 1'b1), mk_data(32'h0012_0000, 1'b0, 1'b0, 4'd7), 8'h00);
    put(5, mk_tag(32'h4000_0000, 3'd2, 1'b0), mk_data(32'h0000_0000, 1'b1, 1'b1, 4'd0), 8'h00);
    put(6, mk_tag(32'h5000_0000, 3'd5, 1'b1), mk_data(32'h0070_0000, 1'b0, 1'b0, 4'd4), 8'h00);
    put(7, mk_tag(32'h6000_0000, 3'd1, 1'b1), mk_data(32'h0000_2000, 1'b1, 1'b1, 4'd1), 8'h09);

    for (int n = 0; n < NV; n++) begin
      look(VECS[n].va, VECS[n].kind, VECS[n].user, VECS[n].pid);
      chk($sformatf("vector %0d", n), "result", pk(v_a, st_a, pa_a, sz_a, ix_a),
          pk(1'b1, VECS[n].st, VECS[n].pa, VECS[n].sz, VECS[n].ix));
    end

    // R9 zones disabled: own bits only
    look(32'h01AB_CDEF, 2'd1, 1'b0, 8'h05);
    chk("R9", "nz write zone2", pk(v_b, st_b, pa_b, sz_b, ix_b), pk(1'b1, 2'd1, 32'h0, 3'd0, 3'd2));
    look(32'h2000_07FF, 2'd2, 1'b1, 8'h05);
    chk("R9", "nz fetch zone3", pk(v_b, st_b, pa_b, sz_b, ix_b), pk(1'b1, 2'd1, 32'h0, 3'd0, 3'd3));
    look(32'h500F_0000, 2'd0, 1'b1, 8'h05);
    chk("R9", "nz user zone0", pk(v_b, st_b, pa_b, sz_b, ix_b), pk(1'b1, 2'd2, 32'h007F_0000, 3'd5, 3'd6));

    // R10 idle request
    @(negedge clk); rq_v = 1'b0;
    @(posedge clk); #1;
    chk("R10", "idle valid", 64'(v_a), 64'd0);

    // R12 R5 R4 rewrite entry 7 to overlap entry 6
    put(7, mk_tag(32'h500F_0000, 3'd1, 1'b1), mk_data(32'h0000_A000, 1'b0, 1'b0, 4'd0), 8'h00);
    look(32'h500F_0000, 2'd0, 1'b1, 8'h05);
    chk("R5", "user skips to next", pk(v_a, st_a, pa_a, sz_a, ix_a), pk(1'b1, 2'd2, 32'h0000_A000, 3'd1, 3'd7));
    look(32'h500F_0000, 2'd0, 1'b0, 8'h05);
    chk("R4", "lowest index wins", pk(v_a, st_a, pa_a, sz_a, ix_a), pk(1'b1, 2'd2, 32'h007F_0000, 3'd5, 3'd6));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule